// File: doc/BRIEF.md
# Overlay Fast-Switch Alignment and Source Mixer

This block lines up three pixel-rate streams and then picks one output pixel per clock. The streams are a composite-decoded pixel stream, a component (RGB or YUV) pixel stream, and an overlay fast-switch control. The control arrives as four subsamples per pixel, taken at four times the pixel rate. The composite stream passes through a fixed reference latency. The component stream and the overlay control each pass through a tapped delay line, and a configuration code picks the tap. This lets each of them move earlier or later than the composite stream by a signed whole number of pixels.

After alignment, the block counts how many of the four subsamples are asserted. That count sets the source weight. A high count selects the component pixel, a partial count selects the mean of the two pixels, and a zero count selects the composite pixel. The delay lines clear on reset. Each time reset releases or a code is written, the output shows only the composite pixel until the lines have filled again.

Configuration is a one-cycle write strobe with a target select and a 7-bit data word. The current codes and a rounding flag are visible as outputs.

Top module: `fsw_overlay_align`

## Requirements
- R1: While `rst_n` is low, and for the two clock edges after it rises, `mix_pix` is 0, `ovl_code` is 23 (17h), `cmp_code` is 86 (56h) and `cmp_odd_flag` is 0. The first edge that updates the logic is the third rising edge after release.
- R2: The composite stream has a fixed latency of 86 pixels. Together with the output register, `mix_pix` after edge t is formed from the `cvbs_pix` value sampled at edge t-86.
- R3: The component stream uses `cmp_code` c as its tap. The value at edge t-c reaches the mixer at edge t, which is a shift of c-86 pixels relative to composite (86 = aligned, 0 = 86 pixels early). A component code write stores the data with bit 0 cleared, and any result above 94 stores 94.
- R4: The overlay control uses `ovl_code` o. The subsamples taken at edge t-(63+o) decide the mix at edge t, which is a shift of o-23 pixels relative to composite (23 = aligned, 31 = 8 later, 0 = 23 earlier).
- R5: When the aligned subsample count is 3 or 4 and the lines are filled, `mix_pix` takes the aligned component pixel.
- R6: When the aligned count is 1 or 2 and the lines are filled, `mix_pix` is floor((composite + component) / 2) of the aligned pixels.
- R7: When the aligned count is 0 and the lines are filled, `mix_pix` takes the aligned composite pixel.
- R8: For the 94 mixer updates after the logic starts, and for the 94 after any accepted write, `mix_pix` takes the aligned composite pixel whatever the subsamples are.
- R9: `cmp_odd_flag` takes data bit 0 of each component code write. Overlay code writes leave it unchanged.
- R10: A write with `cfg_sel`=0 loads `cfg_wdata[4:0]` into `ovl_code` and leaves `cmp_code` unchanged. A write with `cfg_sel`=1 updates only the component code and the flag. The new code is visible after the write edge and first applies at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cvbs_pix | input | PIX_W | Composite-decoded pixel |
| comp_pix | input | PIX_W | Component pixel |
| fsw_sub | input | 4 | Four fast-switch subsamples of the current pixel |
| cfg_we | input | 1 | One-cycle code write strobe |
| cfg_sel | input | 1 | Write target: 0 overlay code, 1 component code |
| cfg_wdata | input | 7 | Write data |
| ovl_code | output | 5 | Current overlay delay code |
| cmp_code | output | 7 | Current component delay code |
| cmp_odd_flag | output | 1 | Last component write was odd and was rounded down |
| mix_pix | output | PIX_W | Selected or averaged output pixel |

## Verification
The assertions assume that all inputs are synchronous to `clk`, that `fsw_sub` already holds the four subsamples of one pixel, and that a write strobe lasts one cycle with select and data stable while it is high. The stimulus changes inputs only on falling edges and raises `cfg_we` for exactly one cycle per write. Subsample patterns are drawn so that every count from 0 to 4 occurs under each code setting. The writes include odd, out-of-range and extreme codes, which exercises the rounding, the clamp and the refill guard.

// File: rtl/fsw_align_pkg.sv
package fsw_align_pkg;
  localparam int OVL_W      = 5;
  localparam int CMP_W      = 7;
  localparam int OVL_ZERO   = 23;
  localparam int CMP_ZERO   = 86;
  localparam int CMP_MAX    = 94;
  localparam int LINE_DEPTH = CMP_MAX;
  localparam int TAP_W      = $clog2(LINE_DEPTH + 1);
  localparam int OVL_BASE   = CMP_ZERO - OVL_ZERO;
  localparam int SUBS       = 4;
  localparam int WGT_W      = $clog2(SUBS + 1);
endpackage

// File: rtl/fsw_rst_sync.sv
module fsw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic s1_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      s1_q   <= 1'b1;
      rst_ni <= s1_q;
    end
  end
endmodule

// File: rtl/fsw_tap_line.sv
module fsw_tap_line #(
  parameter int W     = 10,
  parameter int DEPTH = 94,
  localparam int TW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [W-1:0]  din,
  input  logic [TW-1:0] tap,
  output logic [W-1:0]  dout
);
  logic [W-1:0] sr_q [DEPTH];
  logic [W-1:0] sr_d [DEPTH];

  always_comb begin
    sr_d[0] = din;
    for (int i = 1; i < DEPTH; i++) sr_d[i] = sr_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= sr_d[i];
    end
  end

  always_comb begin
    if (tap == '0)                 dout = din;
    else if (int'(tap) > DEPTH)    dout = sr_q[DEPTH-1];
    else                           dout = sr_q[tap - TW'(1)];
  end
endmodule

// File: rtl/fsw_cfg_regs.sv
module fsw_cfg_regs
  import fsw_align_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CMP_W-1:0] cfg_wdata,
  output logic [OVL_W-1:0] ovl_q,
  output logic [CMP_W-1:0] cmp_q,
  output logic             odd_q
);
  logic [OVL_W-1:0] ovl_d;
  logic [CMP_W-1:0] cmp_d;
  logic [CMP_W-1:0] rnd;
  logic             odd_d;

  always_comb begin
    ovl_d = ovl_q;
    cmp_d = cmp_q;
    odd_d = odd_q;
    rnd   = {cfg_wdata[CMP_W-1:1], 1'b0};
    if (cfg_we) begin
      if (cfg_sel) begin
        cmp_d = (int'(rnd) > CMP_MAX) ? CMP_W'(CMP_MAX) : rnd;
        odd_d = cfg_wdata[0];
      end else begin
        ovl_d = cfg_wdata[OVL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ovl_q <= OVL_W'(OVL_ZERO);
      cmp_q <= CMP_W'(CMP_ZERO);
      odd_q <= 1'b0;
    end else if (cfg_we) begin
      ovl_q <= ovl_d;
      cmp_q <= cmp_d;
      odd_q <= odd_d;
    end
  end

  p_cmp_even_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmp_q[0] == 1'b0) && (int'(cmp_q) <= CMP_MAX));
  p_odd_flag_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_we && cfg_sel) |=> (odd_q == $past(cfg_wdata[0])));
  p_ovl_only_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_we && !cfg_sel) |=> ($stable(cmp_q) && $stable(odd_q)));
endmodule

// File: rtl/fsw_overlay_align.sv
module fsw_overlay_align
  import fsw_align_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] cvbs_pix,
  input  logic [PIX_W-1:0] comp_pix,
  input  logic [3:0]       fsw_sub,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [6:0]       cfg_wdata,
  output logic [4:0]       ovl_code,
  output logic [6:0]       cmp_code,
  output logic             cmp_odd_flag,
  output logic [PIX_W-1:0] mix_pix
);
  logic             rst_i;
  logic [PIX_W-1:0] cvbs_tap, comp_tap, avg_pix, mix_d;
  logic [PIX_W:0]   sum_pix;
  logic [SUBS-1:0]  fsw_tap;
  logic [TAP_W-1:0] ovl_tap, cmp_tap;
  logic [WGT_W-1:0] wgt;
  logic [TAP_W-1:0] fill_q, fill_d;
  logic             filled, fill_en;

  fsw_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ni(rst_i));

  fsw_cfg_regs u_cfg (
    .clk(clk), .rst_ni(rst_i), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ovl_q(ovl_code), .cmp_q(cmp_code), .odd_q(cmp_odd_flag)
  );

  assign ovl_tap = TAP_W'(OVL_BASE) + TAP_W'(ovl_code);
  assign cmp_tap = TAP_W'(cmp_code);

  fsw_tap_line #(.W(PIX_W), .DEPTH(LINE_DEPTH)) u_cvbs (
    .clk(clk), .rst_ni(rst_i), .din(cvbs_pix), .tap(TAP_W'(CMP_ZERO)), .dout(cvbs_tap));
  fsw_tap_line #(.W(PIX_W), .DEPTH(LINE_DEPTH)) u_comp (
    .clk(clk), .rst_ni(rst_i), .din(comp_pix), .tap(cmp_tap), .dout(comp_tap));
  fsw_tap_line #(.W(SUBS), .DEPTH(LINE_DEPTH)) u_fsw (
    .clk(clk), .rst_ni(rst_i), .din(fsw_sub), .tap(ovl_tap), .dout(fsw_tap));

  // fill guard: composite only until the deepest tap holds fresh data
  assign filled  = (fill_q == TAP_W'(LINE_DEPTH));
  assign fill_en = cfg_we || !filled;
  assign fill_d  = cfg_we ? '0 : fill_q + TAP_W'(1);

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)       fill_q <= '0;
    else if (fill_en) fill_q <= fill_d;
  end

  // phase weight and source pick
  always_comb begin
    wgt     = WGT_W'($countones(fsw_tap));
    sum_pix = {1'b0, cvbs_tap} + {1'b0, comp_tap};
    avg_pix = PIX_W'(sum_pix >> 1);
    if (!filled)                   mix_d = cvbs_tap;
    else if (wgt >= WGT_W'(3))     mix_d = comp_tap;
    else if (wgt != '0)            mix_d = avg_pix;
    else                           mix_d = cvbs_tap;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) mix_pix <= '0;
    else        mix_pix <= mix_d;
  end

  p_force_cvbs_r8: assert property (@(posedge clk) disable iff (!rst_i)
    !filled |=> (mix_pix == $past(cvbs_tap)));
  p_fill_restart_r8: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_we |=> (fill_q == '0));
  p_pick_comp_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (filled && ($countones(fsw_tap) >= 3)) |=> (mix_pix == $past(comp_tap)));
  p_pick_cvbs_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (filled && (fsw_tap == '0)) |=> (mix_pix == $past(cvbs_tap)));
endmodule

// File: tb/sim_fsw_overlay_align.sv
`timescale 1ns/1ps
module sim_fsw_overlay_align;
  localparam int W = 10;
  localparam int HN = 4096;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cvbs_pix = '0, comp_pix = '0;
  logic [3:0]   fsw_sub = '0;
  logic         cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [6:0]   cfg_wdata = '0;
  logic [4:0]   ovl_code;
  logic [6:0]   cmp_code;
  logic         cmp_odd_flag;
  logic [W-1:0] mix_pix;

  always #2 clk = ~clk;

  fsw_overlay_align #(.PIX_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cvbs_pix(cvbs_pix), .comp_pix(comp_pix),
    .fsw_sub(fsw_sub), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ovl_code(ovl_code), .cmp_code(cmp_code), .cmp_odd_flag(cmp_odd_flag),
    .mix_pix(mix_pix));

  int checks = 0, failures = 0;
  int e = 0;
  int hist [3][HN];
  int m_ovl = 23, m_cmp = 86, m_odd = 0, m_fill = 0;
  int exp_mix = 0;
  string exp_tag = "R1";
  bit cmp_on = 1'b0;

  function automatic int tapv(int k, int d, int now);
    if (d == 0) return now;
    if (e - d >= 0) return hist[k][e - d];
    return 0;
  endfunction

  // behavioural reference, evaluated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e = 0; m_ovl = 23; m_cmp = 86; m_odd = 0; m_fill = 0; exp_mix = 0; exp_tag = "R1";
    end else begin
      e++;
      if (e < HN) begin
        if (e < 3) begin
          hist[0][e] = 0; hist[1][e] = 0; hist[2][e] = 0;
        end else begin
          int tcv, tcp, tfs, n;
          tcv = tapv(0, 86, int'(cvbs_pix));
          tcp = tapv(1, m_cmp, int'(comp_pix));
          tfs = tapv(2, 63 + m_ovl, int'(fsw_sub));
          n = $countones(4'(tfs));
          if (m_fill < 94)  begin exp_mix = tcv; exp_tag = "R8"; end
          else if (n >= 3)  begin exp_mix = tcp; exp_tag = "R5"; end
          else if (n > 0)   begin exp_mix = (tcv + tcp) / 2; exp_tag = "R6"; end
          else              begin exp_mix = tcv; exp_tag = "R7"; end
          hist[0][e] = int'(cvbs_pix);
          hist[1][e] = int'(comp_pix);
          hist[2][e] = int'(fsw_sub);
          if (cfg_we) begin
            if (cfg_sel) begin
              m_cmp = int'(cfg_wdata) & 126;
              if (m_cmp > 94) m_cmp = 94;
              m_odd = int'(cfg_wdata[0]);
            end else begin
              m_ovl = int'(cfg_wdata[4:0]);
            end
            m_fill = 0;
          end else if (m_fill < 94) begin
            m_fill++;
          end
        end
      end
    end
  end

  // per-pixel comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (int'(mix_pix) != exp_mix) begin
        failures++;
        $display("FAIL %s (R2/R3/R4 alignment) mix_pix actual=%0d expected=%0d at edge %0d",
                 exp_tag, mix_pix, exp_mix, e);
      end
    end
  end

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [3:0] pick_fsw(int mode);
    logic [3:0] pats [6] = '{4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111, 4'b1010};
    logic [3:0] two  [4] = '{4'b0001, 4'b0100, 4'b0110, 4'b1001};
    if (mode == 0) return 4'($urandom);
    if (mode == 1) return pats[$urandom % 6];
    return two[$urandom % 4];
  endfunction

  task automatic run(int n, int mode);
    repeat (n) begin
      @(negedge clk);
      cvbs_pix = W'($urandom);
      comp_pix = W'($urandom);
      fsw_sub  = pick_fsw(mode);
    end
  endtask

  task automatic wr(bit sel, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 7'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mix in reset", int'(mix_pix), 0);
    chk("R1 ovl_code reset", int'(ovl_code), 23);
    chk("R1 cmp_code reset", int'(cmp_code), 86);
    chk("R1 flag reset", int'(cmp_odd_flag), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    run(250, 1);
    run(150, 0);
    // R4 overlay shifts
    wr(1'b0, 8'h1B); chk("R10 ovl_code after write", int'(ovl_code), 27);
    chk("R10 cmp_code kept", int'(cmp_code), 86);
    run(250, 1);
    wr(1'b0, 0);     chk("R4 ovl_code min", int'(ovl_code), 0);
    run(250, 1);
    wr(1'b0, 31);    chk("R4 ovl_code max", int'(ovl_code), 31);
    run(250, 0);
    // R3 component shifts and rounding
    wr(1'b1, 8'h57); chk("R3 odd rounded down", int'(cmp_code), 86);
    chk("R9 flag set", int'(cmp_odd_flag), 1);
    run(250, 1);
    wr(1'b1, 0);     chk("R3 cmp_code zero", int'(cmp_code), 0);
    chk("R9 flag cleared", int'(cmp_odd_flag), 0);
    run(250, 1);
    wr(1'b1, 8'h7F); chk("R3 clamp to 94", int'(cmp_code), 94);
    chk("R9 flag on clamp odd", int'(cmp_odd_flag), 1);
    wr(1'b0, 23);    chk("R9 flag kept by overlay write", int'(cmp_odd_flag), 1);
    chk("R10 cmp kept by overlay write", int'(cmp_code), 94);
    run(250, 1);
    wr(1'b1, 8'h5E); chk("R3 even accepted", int'(cmp_code), 94);
    chk("R9 flag clear on even", int'(cmp_odd_flag), 0);
    run(250, 2);
    wr(1'b1, 96);    chk("R3 even above range clamped", int'(cmp_code), 94);
    run(200, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule